// File: doc/BRIEF.md
# SPI NOR Flash Transaction Checker

This block watches, without driving anything, a byte-level SPI stream going to a serial NOR flash. A front end that deserialises the bus hands it one strobe per transferred byte, with the byte shifted out by the controller and the byte returned by the flash, and a separate strobe each time chip select changes level. The checker treats the first byte of each transaction as the opcode, sorts it into a command class, shifts in the 24-bit address of addressed commands, and counts the data bytes.

Across transactions it keeps a shadow copy of the flash's write-enable latch. The shadow is set and cleared by the enable and disable opcodes and is reloaded from every status byte the flash returns. It uses this shadow to flag program and erase commands that arrive while writes are still locked. It also flags sector erases aimed at an address that is not sector-aligned, and opcodes it does not recognise. When a program or read transaction closes, it issues a one-cycle report with the final address and byte count. It suits a protocol monitor or a debug trace on a chip that contains a flash controller.

Top module: `spi_flash_txn_checker`

## Requirements
- R1: After reset, `cmd_code`, `addr`, `data_count`, `wel`, `txn_open`, `report_vld` and all three warning outputs are zero.
- R2: A byte strobe with no transaction open starts one if the opcode is known. From the next cycle `cmd_code` holds the opcode and `txn_open` is 1. The default opcodes are read 0x03, fast read 0x0B, page program 0x02, sector erase 0x20, chip erase 0xC7 or 0x60, write enable 0x06, write disable 0x04 and status read 0x05.
- R3: For read, fast read, page program and sector erase, bytes 2, 3 and 4 of the transaction form `addr`, most significant byte first. Byte 2 lands in bits 23..16.
- R4: `data_count` is cleared on address byte 4. For read and page program it then counts every byte from index 5 onward. For fast read, byte 5 is a dummy and counting starts at index 6.
- R5: Opcode 0x06 sets `wel` and opcode 0x04 clears it. Each byte after the opcode of a status read copies bit 1 of the returned (MISO) byte into `wel`. `wel` keeps its value across chip-select changes.
- R6: Page program, sector erase and both chip-erase opcodes pulse `warn_no_wren` for one cycle, one cycle after the opcode byte, when `wel` is 0 as that opcode arrives. When `wel` is 1 there is no pulse.
- R7: A sector erase whose assembled address has any of bits 11..0 set pulses `warn_misalign` one cycle after address byte 4. An address that is a multiple of 4096 gives no pulse.
- R8: A chip-select strobe closes the open transaction. For read, fast read and page program, `report_vld` pulses in the next cycle while `addr` and `data_count` show the final values. Other classes close without a report.
- R9: An unrecognised opcode pulses `warn_unknown`, leaves `txn_open` at 0, and the following byte is taken as a new opcode.
- R10: Bytes that a command does not use are ignored. They are not decoded as opcodes, do not change `wel`, and do not change `addr` after byte 4.
- R11: When a chip-select strobe and a byte strobe arrive in the same cycle, the old transaction closes and reports first, and the byte is then taken as the opcode of a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| byte_vld | input | 1 | One byte pair was transferred this cycle |
| mosi_byte | input | 8 | Byte sent by the controller |
| miso_byte | input | 8 | Byte returned by the flash |
| cs_evt | input | 1 | Chip select changed level this cycle |
| cmd_code | output | 8 | Opcode of the current or last transaction |
| txn_open | output | 1 | A recognised transaction is in progress |
| addr | output | 24 | Assembled address |
| data_count | output | 16 | Data bytes counted in the data phase |
| report_vld | output | 1 | One-cycle pulse: a data-bearing transaction closed |
| wel | output | 1 | Write-enable latch shadow |
| warn_no_wren | output | 1 | Program or erase arrived while writes were locked |
| warn_misalign | output | 1 | Sector erase address not 4096-aligned |
| warn_unknown | output | 1 | Unrecognised opcode |

## Verification
The assertions assume that the front end never raises `byte_vld` or `cs_evt` during reset. They also assume that byte and opcode values are stable for the single cycle their strobe is high. The status-reload property further assumes that only one of set, clear and reload is requested in any cycle, which holds because they depend on mutually exclusive decode states. The stimulus drives every strobe for exactly one cycle, on the falling clock edge and after reset has been released, so each event is seen once and in order. Only the R11 case raises both strobes together, on purpose.

// File: rtl/spi_chk_pkg.sv
package spi_chk_pkg;

    typedef enum logic [3:0] {
        CL_NONE,
        CL_READ,
        CL_FAST,
        CL_PROG,
        CL_SECT,
        CL_CHIP,
        CL_WEN,
        CL_WDIS,
        CL_STAT
    } cmd_class_e;

    // Classes whose bytes 2..4 carry an address
    function automatic logic has_addr(cmd_class_e c);
        return (c == CL_READ) || (c == CL_FAST) || (c == CL_PROG) || (c == CL_SECT);
    endfunction

    // Classes that close with an address/count report
    function automatic logic carries_data(cmd_class_e c);
        return (c == CL_READ) || (c == CL_FAST) || (c == CL_PROG);
    endfunction

    // Classes that modify the array and need the latch set
    function automatic logic needs_wen(cmd_class_e c);
        return (c == CL_PROG) || (c == CL_SECT) || (c == CL_CHIP);
    endfunction

endpackage

// File: rtl/spi_chk_cmd_decode.sv
module spi_chk_cmd_decode
    import spi_chk_pkg::*;
#(
    parameter logic [7:0] OP_READ  = 8'h03,
    parameter logic [7:0] OP_FAST  = 8'h0B,
    parameter logic [7:0] OP_PROG  = 8'h02,
    parameter logic [7:0] OP_SECT  = 8'h20,
    parameter logic [7:0] OP_CHIPA = 8'hC7,
    parameter logic [7:0] OP_CHIPB = 8'h60,
    parameter logic [7:0] OP_WEN   = 8'h06,
    parameter logic [7:0] OP_WDIS  = 8'h04,
    parameter logic [7:0] OP_STAT  = 8'h05
) (
    input  logic [7:0] opcode,
    output cmd_class_e cls
);

    always_comb begin
        if      (opcode == OP_READ)                          cls = CL_READ;
        else if (opcode == OP_FAST)                          cls = CL_FAST;
        else if (opcode == OP_PROG)                          cls = CL_PROG;
        else if (opcode == OP_SECT)                          cls = CL_SECT;
        else if (opcode == OP_CHIPA || opcode == OP_CHIPB)   cls = CL_CHIP;
        else if (opcode == OP_WEN)                           cls = CL_WEN;
        else if (opcode == OP_WDIS)                          cls = CL_WDIS;
        else if (opcode == OP_STAT)                          cls = CL_STAT;
        else                                                 cls = CL_NONE;
    end

endmodule

// File: rtl/spi_chk_wel.sv
module spi_chk_wel (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic load_i,
    input  logic load_val_i,
    output logic wel_o
);

    logic wel_d, wel_q;

    always_comb begin
        wel_d = wel_q;
        if (set_i)       wel_d = 1'b1;
        else if (clr_i)  wel_d = 1'b0;
        else if (load_i) wel_d = load_val_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wel_q <= 1'b0;
        else        wel_q <= wel_d;
    end

    assign wel_o = wel_q;

    a_r5_enable_sets: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> wel_q);

    a_r5_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !wel_q);

    a_r5_reload_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !set_i && !clr_i) |=> (wel_q == $past(load_val_i)));

    a_r10_hold_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && !load_i) |=> $stable(wel_q));

endmodule

// File: rtl/spi_flash_txn_checker.sv
module spi_flash_txn_checker
    import spi_chk_pkg::*;
#(
    parameter int         ADDR_BYTES = 3,
    parameter int         IDX_W      = 4,
    parameter int         CNT_W      = 16,
    parameter int         SECTOR_LG2 = 12,
    parameter logic [7:0] OP_READ    = 8'h03,
    parameter logic [7:0] OP_FAST    = 8'h0B,
    parameter logic [7:0] OP_PROG    = 8'h02,
    parameter logic [7:0] OP_SECT    = 8'h20,
    parameter logic [7:0] OP_CHIPA   = 8'hC7,
    parameter logic [7:0] OP_CHIPB   = 8'h60,
    parameter logic [7:0] OP_WEN     = 8'h06,
    parameter logic [7:0] OP_WDIS    = 8'h04,
    parameter logic [7:0] OP_STAT    = 8'h05,
    parameter int         WEL_BIT    = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      byte_vld,
    input  logic [7:0]                mosi_byte,
    input  logic [7:0]                miso_byte,
    input  logic                      cs_evt,
    output logic [7:0]                cmd_code,
    output logic                      txn_open,
    output logic [8*ADDR_BYTES-1:0]   addr,
    output logic [CNT_W-1:0]          data_count,
    output logic                      report_vld,
    output logic                      wel,
    output logic                      warn_no_wren,
    output logic                      warn_misalign,
    output logic                      warn_unknown
);

    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam logic [IDX_W:0]   POS_ADDR_LO  = (IDX_W+1)'(2);
    localparam logic [IDX_W:0]   POS_ADDR_HI  = (IDX_W+1)'(ADDR_BYTES + 1);
    localparam logic [IDX_W:0]   POS_DATA     = (IDX_W+1)'(ADDR_BYTES + 2);
    localparam logic [IDX_W:0]   POS_DATA_DUM = (IDX_W+1)'(ADDR_BYTES + 3);
    localparam logic [IDX_W-1:0] IDX_MAX      = '1;
    localparam logic [CNT_W-1:0] CNT_MAX      = '1;

    typedef struct packed {
        logic              open;
        cmd_class_e        cls;
        logic [7:0]        cmd;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              rep;
        logic              w_wen;
        logic              w_sec;
        logic              w_unk;
    } chk_state_t;

    chk_state_t st_d, st_q;
    cmd_class_e dec_cls;
    logic       still_open;
    logic [IDX_W:0] pos;
    logic       wel_set, wel_clr, wel_load;

    spi_chk_cmd_decode #(
        .OP_READ (OP_READ),  .OP_FAST (OP_FAST),  .OP_PROG (OP_PROG),
        .OP_SECT (OP_SECT),  .OP_CHIPA(OP_CHIPA), .OP_CHIPB(OP_CHIPB),
        .OP_WEN  (OP_WEN),   .OP_WDIS (OP_WDIS),  .OP_STAT (OP_STAT)
    ) dec_i (
        .opcode (mosi_byte),
        .cls    (dec_cls)
    );

    spi_chk_wel wel_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (wel_set),
        .clr_i      (wel_clr),
        .load_i     (wel_load),
        .load_val_i (miso_byte[WEL_BIT]),
        .wel_o      (wel)
    );

    // A chip-select event closes the transaction before the byte is looked at
    assign still_open = st_q.open && !cs_evt;

    always_comb begin
        st_d       = st_q;
        st_d.rep   = 1'b0;
        st_d.w_wen = 1'b0;
        st_d.w_sec = 1'b0;
        st_d.w_unk = 1'b0;
        wel_set    = 1'b0;
        wel_clr    = 1'b0;
        wel_load   = 1'b0;
        pos        = {1'b0, st_q.idx} + 1'b1;

        if (cs_evt) begin
            st_d.open = 1'b0;
            if (st_q.open && carries_data(st_q.cls)) st_d.rep = 1'b1;
        end

        if (byte_vld) begin
            if (!still_open) begin
                if (dec_cls == CL_NONE) begin
                    st_d.w_unk = 1'b1;
                    st_d.open  = 1'b0;
                end else begin
                    st_d.open = 1'b1;
                    st_d.cls  = dec_cls;
                    st_d.cmd  = mosi_byte;
                    st_d.idx  = IDX_W'(1);
                    if (needs_wen(dec_cls) && !wel) st_d.w_wen = 1'b1;
                    wel_set = (dec_cls == CL_WEN);
                    wel_clr = (dec_cls == CL_WDIS);
                end
            end else begin
                if (st_q.idx != IDX_MAX) st_d.idx = st_q.idx + 1'b1;

                if (has_addr(st_q.cls) && pos >= POS_ADDR_LO && pos <= POS_ADDR_HI) begin
                    st_d.addr = {st_q.addr[ADDR_W-9:0], mosi_byte};
                    if (pos == POS_ADDR_HI) begin
                        st_d.cnt = '0;
                        if (st_q.cls == CL_SECT && st_d.addr[SECTOR_LG2-1:0] != '0)
                            st_d.w_sec = 1'b1;
                    end
                end

                if ((((st_q.cls == CL_READ) || (st_q.cls == CL_PROG)) && pos >= POS_DATA) ||
                    ((st_q.cls == CL_FAST) && pos >= POS_DATA_DUM)) begin
                    if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
                end

                if (st_q.cls == CL_STAT) wel_load = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_code      = st_q.cmd;
    assign txn_open      = st_q.open;
    assign addr          = st_q.addr;
    assign data_count    = st_q.cnt;
    assign report_vld    = st_q.rep;
    assign warn_no_wren  = st_q.w_wen;
    assign warn_misalign = st_q.w_sec;
    assign warn_unknown  = st_q.w_unk;

    a_r9_unknown_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !still_open && dec_cls == CL_NONE) |=> (warn_unknown && !txn_open));

    a_r8_report_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
        report_vld |-> $past(cs_evt));

    a_r4_count_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(data_count));

    a_r3_addr_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |=> $stable(addr));

    a_r6_warn_only_when_locked: assert property (@(posedge clk) disable iff (!rst_n)
        warn_no_wren |-> !wel);

    a_r7_misalign_only_sector: assert property (@(posedge clk) disable iff (!rst_n)
        warn_misalign |-> (st_q.cls == CL_SECT && addr[SECTOR_LG2-1:0] != '0));

endmodule

// File: tb/spi_flash_txn_checker_tb_top.sv
module spi_flash_txn_checker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_vld = 1'b0;
    logic [7:0]  mosi_byte = '0;
    logic [7:0]  miso_byte = '0;
    logic        cs_evt = 1'b0;
    logic [7:0]  cmd_code;
    logic        txn_open;
    logic [23:0] addr;
    logic [15:0] data_count;
    logic        report_vld, wel, warn_no_wren, warn_misalign, warn_unknown;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    spi_flash_txn_checker dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .mosi_byte(mosi_byte),
        .miso_byte(miso_byte), .cs_evt(cs_evt), .cmd_code(cmd_code),
        .txn_open(txn_open), .addr(addr), .data_count(data_count),
        .report_vld(report_vld), .wel(wel), .warn_no_wren(warn_no_wren),
        .warn_misalign(warn_misalign), .warn_unknown(warn_unknown)
    );

    typedef struct packed {
        logic [7:0]  op;
        logic [23:0] adr;
        logic [7:0]  nb;
        logic [15:0] cnt;
        logic        nowren;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{8'h03, 24'h123456, 8'd3, 16'd3, 1'b0},
        '{8'h0B, 24'hABCDEF, 8'd4, 16'd4, 1'b0},
        '{8'h02, 24'h000100, 8'd2, 16'd2, 1'b1},
        '{8'h03, 24'hFFFFFF, 8'd0, 16'd0, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one byte pair for a cycle; returns at the next falling edge,
    // when registered results of that byte are visible.
    task automatic send(input logic [7:0] m, input logic [7:0] s);
        @(negedge clk);
        byte_vld = 1'b1; mosi_byte = m; miso_byte = s;
        @(negedge clk);
        byte_vld = 1'b0;
    endtask

    task automatic cs_toggle();
        @(negedge clk);
        cs_evt = 1'b1;
        @(negedge clk);
        cs_evt = 1'b0;
    endtask

    task automatic send_addr(input logic [23:0] a);
        send(a[23:16], 8'h00);
        send(a[15:8],  8'h00);
        send(a[7:0],   8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cmd_code", 32'(cmd_code), 0);
        chk("R1 addr", 32'(addr), 0);
        chk("R1 count", 32'(data_count), 0);
        chk("R1 flags", {report_vld, wel, txn_open, warn_no_wren, warn_misalign, warn_unknown}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after release", {report_vld, wel, txn_open}, 0);

        // Table walk: R2 R3 R4 R6 R8
        for (int i = 0; i < 4; i++) begin
            send(VEC[i].op, 8'h00);
            chk("R2 cmd_code", 32'(cmd_code), 32'(VEC[i].op));
            chk("R2 txn_open", 32'(txn_open), 1);
            chk("R6 no-wren warn", 32'(warn_no_wren), 32'(VEC[i].nowren));
            send_addr(VEC[i].adr);
            chk("R3 addr", 32'(addr), 32'(VEC[i].adr));
            if (VEC[i].op == 8'h0B) send(8'hEE, 8'h00);
            for (int j = 0; j < 4; j++)
                if (j < int'(VEC[i].nb)) send(8'(i + j), 8'h55);
            cs_toggle();
            chk("R8 report", 32'(report_vld), 1);
            chk("R8 addr", 32'(addr), 32'(VEC[i].adr));
            chk("R4 count", 32'(data_count), 32'(VEC[i].cnt));
            chk("R8 closed", 32'(txn_open), 0);
        end

        // R5 enable, persistence; R8 no report for non-data command
        send(8'h06, 8'h00);
        chk("R5 wel set", 32'(wel), 1);
        cs_toggle();
        chk("R8 no report", 32'(report_vld), 0);
        chk("R5 wel persists", 32'(wel), 1);

        // R6 program with latch set gives no warning
        send(8'h02, 8'h00);
        chk("R6 no warn when enabled", 32'(warn_no_wren), 0);
        send_addr(24'h001000);
        send(8'h11, 8'h00);
        cs_toggle();

        // R5 disable, R6 both chip-erase codes
        send(8'h04, 8'h00);
        chk("R5 wel cleared", 32'(wel), 0);
        cs_toggle();
        send(8'h60, 8'h00);
        chk("R6 chip erase 60", 32'(warn_no_wren), 1);
        cs_toggle();
        send(8'hC7, 8'h00);
        chk("R6 chip erase C7", 32'(warn_no_wren), 1);
        cs_toggle();

        // R7 misaligned sector erase, R10 extra byte ignored
        send(8'h20, 8'h00);
        chk("R6 sector erase locked", 32'(warn_no_wren), 1);
        send(8'h00, 8'h00);
        send(8'h10, 8'h00);
        chk("R7 no warn before byte 4", 32'(warn_misalign), 0);
        send(8'h01, 8'h00);
        chk("R7 misaligned", 32'(warn_misalign), 1);
        chk("R3 sector addr", 32'(addr), 32'h001001);
        send(8'hAA, 8'h00);
        chk("R10 addr unchanged", 32'(addr), 32'h001001);
        chk("R10 no warn", 32'(warn_misalign), 0);
        cs_toggle();
        chk("R8 sector no report", 32'(report_vld), 0);

        // R7 aligned sector erase
        send(8'h20, 8'h00);
        send_addr(24'h002000);
        chk("R7 aligned", 32'(warn_misalign), 0);
        cs_toggle();

        // R5 status read reloads the shadow from MISO bit 1
        send(8'h05, 8'h02);
        chk("R5 opcode byte no reload", 32'(wel), 0);
        send(8'h00, 8'h02);
        chk("R5 status bit1 set", 32'(wel), 1);
        send(8'h00, 8'hFD);
        chk("R5 status bit1 clear", 32'(wel), 0);
        send(8'h00, 8'h03);
        cs_toggle();
        chk("R5 status persists", 32'(wel), 1);

        // R10 bytes after write enable are not decoded
        send(8'h06, 8'h00);
        send(8'h04, 8'h00);
        chk("R10 trailing opcode ignored", 32'(wel), 1);
        chk("R10 cmd kept", 32'(cmd_code), 32'h06);
        cs_toggle();

        // R9 unknown opcode
        send(8'h9F, 8'h00);
        chk("R9 unknown flag", 32'(warn_unknown), 1);
        chk("R9 stays idle", 32'(txn_open), 0);
        send(8'h03, 8'h00);
        chk("R9 next is opcode", 32'(cmd_code), 32'h03);
        chk("R9 flag cleared", 32'(warn_unknown), 0);

        // R11 close and new opcode in one cycle
        send_addr(24'hA1B2C3);
        send(8'h77, 8'h00);
        @(negedge clk);
        cs_evt = 1'b1; byte_vld = 1'b1; mosi_byte = 8'h04; miso_byte = 8'h00;
        @(negedge clk);
        cs_evt = 1'b0; byte_vld = 1'b0;
        chk("R11 report", 32'(report_vld), 1);
        chk("R11 addr", 32'(addr), 32'hA1B2C3);
        chk("R11 count", 32'(data_count), 1);
        chk("R11 new cmd", 32'(cmd_code), 32'h04);
        chk("R11 new txn open", 32'(txn_open), 1);
        chk("R11 new cmd acted", 32'(wel), 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule